// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives the serial clock for a transmit and a receive channel from the parent clock. Each channel holds a 16-bit scale code. A three-bit exponent field selects a power-of-two divide, one dedicated code bypasses the divider, and a five-bit coarse field adds a further divide by 32 when it is all ones. Each channel produces two outputs at the selected rate. The first is a one-cycle tick, usable as a clock enable. The second is a registered serial clock with 50% duty.

Each channel has its own run enable. While the enable is low, the channel copies its scale input into a shadow register and holds its counter, serial clock and tick at zero. While the enable is high, the shadow code is frozen, so a new rate only takes effect once the channel is idle again. The two channels share no state.

Top module: `spi_clk_prescaler`

## Requirements
- R1: After reset, with both enables low, all serial clock and tick outputs are 0.
- R2: A code whose bits 2:0 hold E (0 to 4), with every other bit 0, divides by N = 2^(E+1). The tick pulses for one cycle every N cycles. The serial clock has period N, is high for N/2 cycles, and the tick coincides with its falling edge.
- R3: Code 0x0007 selects divide-by-one. While enabled, the tick stays high on every cycle and the serial clock stays low.
- R4: A code with bits 12:8 = 0x1F, bits 2:0 = E (0 to 4), and every other bit 0, divides by N = 2^(E+6), which gives 64 to 1024.
- R5: Any other code is reserved and divides by 1024.
- R6: While a channel's enable is low, its counter is cleared and its outputs read 0 one cycle later. When the enable is first sampled high, the serial clock rises after N/2 rising edges and the first tick appears after N rising edges.
- R7: The scale input is captured only on rising edges where the channel enable is low. Changes to it while enabled have no effect on the running rate.
- R8: The transmit and receive channels run independently. A disabled channel stays quiet while the other one runs, and each channel may use a different code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_scale_i | input | 16 | Transmit scale code |
| rx_scale_i | input | 16 | Receive scale code |
| tx_en_i | input | 1 | Transmit clock-output enable |
| rx_en_i | input | 1 | Receive clock-output enable |
| tx_sck_o | output | 1 | Transmit serial clock |
| rx_sck_o | output | 1 | Receive serial clock |
| tx_tick_o | output | 1 | Transmit rate tick |
| rx_tick_o | output | 1 | Receive rate tick |

## Verification
The bench runs every legal exponent, both with the coarse field clear and with it set. This separates the fine stage from the coarse stage. The bypass code shows that divide-by-one suppresses the serial clock. Reserved codes include a bypass exponent with the coarse field set, partial coarse fields and stray upper bits; they show that the decoder does not match these loosely to a legal ratio. Random codes with a fixed seed, mixed channel enables, and scale changes made mid-run separate capture while idle from capture while running. They also show whether the two channels interfere with each other.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int SCALE_W    = 16;
    localparam int LO_W       = 3;
    localparam int HI_LSB     = 8;
    localparam int HI_W       = 5;
    localparam int LO_MAX     = 4;
    localparam int COARSE_EXP = 5;
    localparam int MAX_EXP    = LO_MAX + 1 + COARSE_EXP;
    localparam int EXP_W      = $clog2(MAX_EXP + 1);
    localparam int CNT_W      = MAX_EXP - 1;

    localparam logic [SCALE_W-1:0] BYPASS_CODE = 16'h0007;
    localparam logic [HI_W-1:0]    COARSE_ON   = 5'h1F;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic               sck;
        logic               tick;
        logic [SCALE_W-1:0] scale;
    } chan_state_t;

endpackage

// File: rtl/presc_decode.sv
module presc_decode
    import spi_presc_pkg::*;
(
    input  logic [SCALE_W-1:0] scale_i,
    output logic [EXP_W-1:0]   exp_o
);
    localparam logic [SCALE_W-1:0] FIELD_MASK =
        SCALE_W'((1 << LO_W) - 1) | (SCALE_W'((1 << HI_W) - 1) << HI_LSB);

    logic [LO_W-1:0]    lo;
    logic [HI_W-1:0]    hi;
    logic               stray;
    logic               lo_ok;

    always_comb begin
        lo    = scale_i[LO_W-1:0];
        hi    = scale_i[HI_LSB +: HI_W];
        stray = |(scale_i & ~FIELD_MASK);
        lo_ok = (32'(lo) <= LO_MAX);
        if (scale_i == BYPASS_CODE) begin
            exp_o = '0;
        end else if (!stray && lo_ok && hi == '0) begin
            exp_o = EXP_W'(lo) + EXP_W'(1);
        end else if (!stray && lo_ok && hi == COARSE_ON) begin
            exp_o = EXP_W'(lo) + EXP_W'(1 + COARSE_EXP);
        end else begin
            exp_o = EXP_W'(MAX_EXP);
        end
    end

endmodule

// File: rtl/presc_channel.sv
module presc_channel
    import spi_presc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               sck_o,
    output logic               tick_o
);
    chan_state_t      st_d, st_q;
    logic [EXP_W-1:0] exp_w;
    logic [CNT_W-1:0] half_m1;
    logic             bypass;
    logic             edge_hit;

    presc_decode u_decode (
        .scale_i (st_q.scale),
        .exp_o   (exp_w)
    );

    always_comb begin
        bypass = (exp_w == '0);
        if (bypass) begin
            half_m1 = '0;
        end else begin
            half_m1 = CNT_W'((32'd1 << (exp_w - EXP_W'(1))) - 32'd1);
        end
    end

    always_comb begin
        st_d     = st_q;
        edge_hit = 1'b0;
        if (!en_i) begin
            st_d.cnt   = '0;
            st_d.sck   = 1'b0;
            st_d.tick  = 1'b0;
            st_d.scale = scale_i;
        end else if (bypass) begin
            st_d.cnt  = '0;
            st_d.sck  = 1'b0;
            st_d.tick = 1'b1;
        end else begin
            edge_hit  = (st_q.cnt == half_m1);
            st_d.cnt  = edge_hit ? '0 : st_q.cnt + CNT_W'(1);
            st_d.sck  = st_q.sck ^ edge_hit;
            st_d.tick = edge_hit & st_q.sck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o  = st_q.sck;
    assign tick_o = st_q.tick;

    // R6: an idle channel is silent on the next cycle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!sck_o && !tick_o));

    // R7: the shadow code is frozen while running
    p_scale_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable(st_q.scale));

    // R2: the counter never passes the half-period limit
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= half_m1);

    // R2: a tick only ever accompanies a falling serial clock
    p_tick_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !bypass) |-> $fell(sck_o));

    // R3: bypass yields a tick on every enabled cycle
    p_bypass_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && bypass) |=> tick_o);

    // R5: the decoded exponent never exceeds the largest ratio
    p_exp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(exp_w) <= MAX_EXP);

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
    import spi_presc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SCALE_W-1:0] tx_scale_i,
    input  logic [SCALE_W-1:0] rx_scale_i,
    input  logic               tx_en_i,
    input  logic               rx_en_i,
    output logic               tx_sck_o,
    output logic               rx_sck_o,
    output logic               tx_tick_o,
    output logic               rx_tick_o
);
    localparam int NUM_CH = 2;

    logic [SCALE_W-1:0] scale_a [NUM_CH];
    logic [NUM_CH-1:0]  en_a;
    logic [NUM_CH-1:0]  sck_a;
    logic [NUM_CH-1:0]  tick_a;

    assign scale_a[0] = tx_scale_i;
    assign scale_a[1] = rx_scale_i;
    assign en_a       = {rx_en_i, tx_en_i};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        presc_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_a[g]),
            .scale_i (scale_a[g]),
            .sck_o   (sck_a[g]),
            .tick_o  (tick_a[g])
        );
    end

    assign tx_sck_o  = sck_a[0];
    assign rx_sck_o  = sck_a[1];
    assign tx_tick_o = tick_a[0];
    assign rx_tick_o = tick_a[1];

    // R8: a disabled receive channel stays quiet regardless of transmit
    p_rx_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_i && tx_en_i) |=> (!rx_sck_o && !rx_tick_o));

endmodule

// File: tb/spi_clk_prescaler_bench.sv
module spi_clk_prescaler_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_scale = '0, rx_scale = '0;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        tx_sck, rx_sck, tx_tick, rx_tick;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_clk_prescaler u_spi_clk_prescaler (
        .clk(clk), .rst_n(rst_n),
        .tx_scale_i(tx_scale), .rx_scale_i(rx_scale),
        .tx_en_i(tx_en), .rx_en_i(rx_en),
        .tx_sck_o(tx_sck), .rx_sck_o(rx_sck),
        .tx_tick_o(tx_tick), .rx_tick_o(rx_tick)
    );

    function automatic int ratio_of(logic [15:0] s);
        if (s == 16'h0007) return 1;
        if (s[15:13] == 0 && s[7:3] == 0 && s[2:0] <= 3'd4) begin
            if (s[12:8] == 5'h00) return 2 << s[2:0];
            if (s[12:8] == 5'h1F) return 64 << s[2:0];
        end
        return 1024;
    endfunction

    function automatic string tag_of(logic [15:0] s);
        if (s == 16'h0007) return "R3";
        if (s[15:13] == 0 && s[7:3] == 0 && s[2:0] <= 3'd4) begin
            if (s[12:8] == 5'h00) return "R2";
            if (s[12:8] == 5'h1F) return "R4";
        end
        return "R5";
    endfunction

    function automatic logic want_sck(int n, int j);
        if (n == 1) return 1'b0;
        return ((j / (n / 2)) % 2) == 1;
    endfunction

    function automatic logic want_tick(int n, int j);
        if (n == 1) return 1'b1;
        return (j % n) == 0;
    endfunction

    task automatic check(logic got, logic exp, string tag, string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Runs both channels; off channels are expected to stay quiet (R8).
    // When disturb is set, scale inputs change mid-run with no effect (R7).
    task automatic run_pair(logic [15:0] ts, logic [15:0] rs, bit t_on, bit r_on, bit disturb);
        int nt = ratio_of(ts);
        int nr = ratio_of(rs);
        int span = 2 * ((nt > nr) ? nt : nr) + 4;
        string tt = disturb ? "R7" : tag_of(ts);
        string rt = disturb ? "R7" : tag_of(rs);
        @(negedge clk);
        tx_en = 0; rx_en = 0; tx_scale = ts; rx_scale = rs;
        @(negedge clk);
        check(tx_sck | tx_tick, 1'b0, "R6", "tx idle");
        check(rx_sck | rx_tick, 1'b0, "R6", "rx idle");
        tx_en = t_on; rx_en = r_on;
        for (int j = 1; j <= span; j++) begin
            @(negedge clk);
            if (t_on) begin
                check(tx_sck,  want_sck(nt, j),  tt, "tx sck");
                check(tx_tick, want_tick(nt, j), tt, "tx tick");
            end else begin
                check(tx_sck | tx_tick, 1'b0, "R8", "tx quiet");
            end
            if (r_on) begin
                check(rx_sck,  want_sck(nr, j),  rt, "rx sck");
                check(rx_tick, want_tick(nr, j), rt, "rx tick");
            end else begin
                check(rx_sck | rx_tick, 1'b0, "R8", "rx quiet");
            end
            if (disturb && j == span / 3) begin
                tx_scale = 16'h0007; rx_scale = 16'h1F04;
            end
        end
        tx_en = 0; rx_en = 0;
        @(negedge clk);
        check(tx_sck | tx_tick, 1'b0, "R6", "tx stop");
        check(rx_sck | rx_tick, 1'b0, "R6", "rx stop");
    endtask

    function automatic logic [15:0] rand_code();
        int k = $urandom_range(0, 3);
        logic [2:0] e = 3'($urandom_range(0, 4));
        case (k)
            0: return {13'h0, e};
            1: return {3'h0, 5'h1F, 5'h0, e};
            2: return 16'h0007;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(negedge clk);
        check(tx_sck | tx_tick | rx_sck | rx_tick, 1'b0, "R1", "in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_sck | tx_tick | rx_sck | rx_tick, 1'b0, "R1", "after reset");

        // R2 fine stage on tx, R4 coarse stage on rx
        for (int e = 0; e <= 4; e++) begin
            run_pair(16'(e), 16'h1F00 | 16'(e), 1, 1, 0);
        end
        // R3 bypass against fine divide
        run_pair(16'h0007, 16'h0000, 1, 1, 0);
        // R5 reserved codes
        run_pair(16'h0005, 16'h1F07, 1, 1, 0);
        run_pair(16'h0100, 16'h8001, 1, 1, 0);
        run_pair(16'h0F02, 16'h0008, 1, 1, 0);
        // R7 mid-run scale changes
        run_pair(16'h0002, 16'h0001, 1, 1, 1);
        // R8 one channel idle
        run_pair(16'h0001, 16'h0000, 1, 0, 0);
        run_pair(16'h0000, 16'h0007, 0, 1, 0);
        // R6 dropout mid-run then restart
        @(negedge clk);
        tx_scale = 16'h0002; tx_en = 0;
        @(negedge clk);
        tx_en = 1;
        repeat (5) @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        check(tx_sck | tx_tick, 1'b0, "R6", "dropout");
        tx_en = 1;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            check(tx_sck, want_sck(8, j), "R6", "restart sck");
        end
        tx_en = 0;
        // random mix
        for (int i = 0; i < 16; i++) begin
            run_pair(rand_code(), rand_code(), 1'($urandom), 1'b1, 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule